// File: doc/BRIEF.md
# Barrier-Aware Round-Robin Warp Scheduler

This block sits at the issue stage of one SIMT multiprocessor and decides which hardware warp issues next. Each of up to `NUM_WARPS` slots holds one of three states: Active, Waiting or Inactive. Every step, the scheduler offers one Active warp on a valid/ready grant stream. The offer is chosen in rotating order, starting at the slot after the warp that last issued. When the issue stage takes the grant, it also reports whether the instruction was a barrier or an end-of-kernel marker. The scheduler then parks the warp in Waiting or retires it to Inactive.

When no warp is Active but some are Waiting, the barrier has been reached by every live warp, and all Waiting warps return to Active together on the next cycle. When every slot is Inactive, the block raises a plain request for a new block set. A launch then switches on slots 0 to count-1. The grant stream obeys back-pressure: while `grant_valid` is high and `grant_ready` is low, the offered warp and all warp states hold. The event strobes count only on a cycle where the handshake completes.

Top module: `warp_sched`

## Requirements
- R1: After reset every slot is Inactive, `grant_valid` is 0 and `need_blocks` is 1.
- R2: A launch (`launch_valid` high while every slot is Inactive) makes slots 0 to `launch_count`-1 Active and resets the rotation so slot 0 is offered first. A count above `NUM_WARPS` is treated as `NUM_WARPS`, and a count of 0 launches nothing.
- R3: A launch request made while any slot is Active or Waiting has no effect.
- R4: While any slot is Active, `grant_valid` is 1 and `grant_id` is the first Active slot at or after the rotation pointer, wrapping past the last slot. After a handshake the pointer moves to the granted slot plus one, wrapping to 0.
- R5: While `grant_valid` is 1 and `grant_ready` is 0, `grant_id` and all slot states hold, and `evt_barrier` and `evt_exit` are ignored.
- R6: A handshake with `evt_barrier` high and `evt_exit` low moves the granted warp to Waiting.
- R7: A handshake with `evt_exit` high moves the granted warp to Inactive, even when `evt_barrier` is also high, and that warp is never offered again until a new launch.
- R8: In a cycle with no Active slot and at least one Waiting slot, `grant_valid` is 0, and on the next cycle every Waiting slot is Active.
- R9: `need_blocks` is 1 exactly when every slot is Inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_valid | input | 1 | Request to start a new block set |
| launch_count | input | $clog2(NUM_WARPS+1) | Number of warps in the new block set |
| grant_valid | output | 1 | A warp is offered for issue |
| grant_ready | input | 1 | Issue stage takes the offered warp |
| grant_id | output | $clog2(NUM_WARPS) | Slot index of the offered warp |
| evt_barrier | input | 1 | Issued instruction was a barrier (qualified by handshake) |
| evt_exit | input | 1 | Issued instruction ended the kernel (qualified by handshake) |
| need_blocks | output | 1 | All slots are Inactive; ask for the next block set |

## Verification
Plain issue with no events and a small warp count shows that the rotation wraps and visits every live slot in order. Stall cycles with both event strobes raised show whether the strobes leak in without a handshake. Barrier-only passes separate the release cycle from ordinary idle. Exit passes, including an exit with a barrier in the same cycle, show retirement, its priority, and the rise of the block request. Clamped, zero and mid-run launches probe the launch guard. A long random mix of ready, events and warp counts is then compared cycle by cycle against a behavioural model.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  typedef enum logic [1:0] {
    WS_INACTIVE = 2'd0,
    WS_ACTIVE   = 2'd1,
    WS_WAITING  = 2'd2
  } wstate_e;

endpackage

// File: rtl/warp_slot.sv
module warp_slot
  import warp_sched_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    launch_en,
  input  logic    issue_hit,
  input  logic    evt_barrier,
  input  logic    evt_exit,
  input  logic    release_all,
  output wstate_e state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WS_INACTIVE;
    end else if (launch_en) begin
      state <= WS_ACTIVE;
    end else if (issue_hit) begin
      if (evt_exit)         state <= WS_INACTIVE;
      else if (evt_barrier) state <= WS_WAITING;
    end else if (release_all && state == WS_WAITING) begin
      state <= WS_ACTIVE;
    end
  end

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N    = 32,
  parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  input  logic [ID_W-1:0] start,
  output logic            found,
  output logic [ID_W-1:0] pick
);

  localparam logic [ID_W:0] N_W = (ID_W+1)'(N);

  logic [ID_W:0] idx;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      idx = {1'b0, start} + (ID_W+1)'(k);
      if (idx >= N_W) idx = idx - N_W;
      if (!found && req[idx[ID_W-1:0]]) begin
        found = 1'b1;
        pick  = idx[ID_W-1:0];
      end
    end
  end

endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int ID_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  parameter int CNT_W     = $clog2(NUM_WARPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_valid,
  input  logic [CNT_W-1:0] launch_count,
  output logic             grant_valid,
  input  logic             grant_ready,
  output logic [ID_W-1:0]  grant_id,
  input  logic             evt_barrier,
  input  logic             evt_exit,
  output logic             need_blocks
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_WARPS);
  localparam logic [ID_W-1:0]  LAST_ID = ID_W'(NUM_WARPS - 1);

  wstate_e               slot_st [NUM_WARPS];
  logic [NUM_WARPS-1:0]  act_mask;
  logic [NUM_WARPS-1:0]  wait_mask;
  logic [ID_W-1:0]       rr_ptr;
  logic                  any_act;
  logic                  any_wait;
  logic [ID_W-1:0]       pick;
  logic                  fire;
  logic                  launch_fire;
  logic                  release_all;
  logic [CNT_W-1:0]      eff_cnt;

  assign any_act     = |act_mask;
  assign any_wait    = |wait_mask;
  assign fire        = any_act && grant_ready;
  assign launch_fire = launch_valid && !any_act && !any_wait;
  assign release_all = !any_act && any_wait;
  assign eff_cnt     = (launch_count > MAX_CNT) ? MAX_CNT : launch_count;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
    logic hit;
    logic lau;
    assign hit = fire && (pick == ID_W'(g));
    assign lau = launch_fire && (CNT_W'(g) < eff_cnt);

    warp_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch_en   (lau),
      .issue_hit   (hit),
      .evt_barrier (evt_barrier),
      .evt_exit    (evt_exit),
      .release_all (release_all),
      .state       (slot_st[g])
    );

    assign act_mask[g]  = (slot_st[g] == WS_ACTIVE);
    assign wait_mask[g] = (slot_st[g] == WS_WAITING);
  end

  rr_picker #(.N(NUM_WARPS), .ID_W(ID_W)) u_pick (
    .req   (act_mask),
    .start (rr_ptr),
    .found (grant_valid),
    .pick  (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (launch_fire) begin
      rr_ptr <= '0;
    end else if (fire) begin
      rr_ptr <= (pick == LAST_ID) ? '0 : pick + 1'b1;
    end
  end

  assign grant_id    = pick;
  assign need_blocks = !any_act && !any_wait;

endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int NUM_WARPS = 32,
  parameter int ID_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  parameter int CNT_W     = $clog2(NUM_WARPS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             launch_valid,
  input logic [CNT_W-1:0] launch_count,
  input logic             grant_valid,
  input logic             grant_ready,
  input logic [ID_W-1:0]  grant_id,
  input logic             need_blocks
);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !grant_ready |=> grant_valid && $stable(grant_id)); // R5

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    need_blocks |-> !grant_valid); // R9

  AST_BARRIER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid && !need_blocks |=> grant_valid); // R8

  AST_LAUNCH_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    need_blocks && launch_valid && launch_count != '0 |=> grant_valid && grant_id == '0); // R2

  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> int'(grant_id) < NUM_WARPS); // R4

endmodule

bind warp_sched warp_sched_chk #(.NUM_WARPS(NUM_WARPS), .ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch_valid (launch_valid),
  .launch_count (launch_count),
  .grant_valid  (grant_valid),
  .grant_ready  (grant_ready),
  .grant_id     (grant_id),
  .need_blocks  (need_blocks)
);

// File: tb/warp_sched_bench.sv
module warp_sched_bench;

  localparam int NW    = 32;
  localparam int ID_W  = 5;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             launch_valid = 1'b0;
  logic [CNT_W-1:0] launch_count = '0;
  logic             grant_valid;
  logic             grant_ready = 1'b0;
  logic [ID_W-1:0]  grant_id;
  logic             evt_barrier = 1'b0;
  logic             evt_exit = 1'b0;
  logic             need_blocks;

  always #4 clk = ~clk;

  warp_sched #(.NUM_WARPS(NW)) u_warp_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_valid (launch_valid),
    .launch_count (launch_count),
    .grant_valid  (grant_valid),
    .grant_ready  (grant_ready),
    .grant_id     (grant_id),
    .evt_barrier  (evt_barrier),
    .evt_exit     (evt_exit),
    .need_blocks  (need_blocks)
  );

  // model: 0 inactive, 1 active, 2 waiting
  int    mst [NW];
  int    mptr;
  int    compared = 0;
  int    mismatched = 0;
  string tag = "R1";
  bit    done = 0;

  task automatic chk(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int m_pick();
    for (int k = 0; k < NW; k++) begin
      int j = (mptr + k) % NW;
      if (mst[j] == 1) return j;
    end
    return -1;
  endfunction

  function automatic int m_count(int v);
    int c = 0;
    for (int i = 0; i < NW; i++) if (mst[i] == v) c++;
    return c;
  endfunction

  // one clock: compare outputs with model, drive inputs, advance model
  task automatic cyc(bit lv, int lc, bit rdy, bit bar, bit ext);
    int p;
    @(negedge clk);
    p = m_pick();
    chk("grant_valid", int'(grant_valid), (p >= 0) ? 1 : 0);
    if (p >= 0) chk("grant_id", int'(grant_id), p);
    chk("need_blocks", int'(need_blocks), (m_count(0) == NW) ? 1 : 0);
    launch_valid = lv;
    launch_count = CNT_W'(lc);
    grant_ready  = rdy;
    evt_barrier  = bar;
    evt_exit     = ext;
    if (lv && m_count(0) == NW) begin
      int n = (lc > NW) ? NW : lc;
      for (int i = 0; i < n; i++) mst[i] = 1;
      mptr = 0;
    end else if (p >= 0) begin
      if (rdy) begin
        if (ext)      mst[p] = 0;
        else if (bar) mst[p] = 2;
        mptr = (p + 1) % NW;
      end
    end else if (m_count(2) > 0) begin
      for (int i = 0; i < NW; i++) if (mst[i] == 2) mst[i] = 1;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) mst[i] = 0;
    mptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    repeat (2) cyc(0, 0, 0, 0, 0);

    tag = "R2";                       // zero count, then clamped count
    cyc(1, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 40, 0, 0, 0);
    repeat (3) cyc(0, 0, 1, 0, 0);

    tag = "R7";                       // retire all 32
    repeat (NW + 2) cyc(0, 0, 1, 0, 1);
    tag = "R9";
    repeat (2) cyc(0, 0, 0, 0, 0);

    tag = "R2";
    cyc(1, 5, 0, 0, 0);
    tag = "R5";                       // stalled, strobes must not count
    repeat (4) cyc(0, 0, 0, 1, 1);
    tag = "R3";                       // launch while busy
    cyc(1, 20, 0, 0, 0);
    repeat (2) cyc(0, 0, 0, 0, 0);

    tag = "R4";
    repeat (12) cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);

    tag = "R6";
    repeat (5) cyc(0, 0, 1, 1, 0);
    tag = "R8";
    repeat (3) cyc(0, 0, 1, 0, 0);

    tag = "R6";                       // partial barrier, rest keep issuing
    cyc(0, 0, 1, 1, 0);
    repeat (4) cyc(0, 0, 1, 0, 0);
    tag = "R7";                       // exit beats barrier
    repeat (8) cyc(0, 0, 1, 1, 1);
    tag = "R8";
    repeat (4) cyc(0, 0, 1, 0, 1);
    tag = "R9";
    repeat (2) cyc(0, 0, 0, 0, 0);

    tag = "R4";                       // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      bit lv  = ($urandom_range(0, 3) == 0);
      int lc  = $urandom_range(0, 40);
      bit rdy = ($urandom_range(0, 3) != 0);
      bit bar = (r < 15);
      bit ext = (r >= 85) || (r < 5);
      cyc(lv, lc, rdy, bar, ext);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule